// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block turns single-word user requests into correctly ordered control waveforms for an external asynchronous static RAM with per-byte lane enables. A request carries a direction flag, an address, write data and a lane select. The sequencer accepts it when idle and then steps through a read or write cycle whose every interval is a whole number of clock cycles given by a parameter. When the cycle ends it returns to idle and pulses `done`.

On the memory side it drives the address, an active-low chip enable, an active-low write strobe, an active-low output enable and one active-low enable per byte lane. The bidirectional data bus is brought out as separate output data, input data and driver-enable pins, so the tristate buffer is placed at the pad. The write strobe is only ever asserted together with chip enable and at least one lane enable. The address only moves between cycles. The data drivers stay off while the memory may still be driving the bus.

A parameter selects whether output enable stays low during writes. When it does, the strobe is stretched so the memory's outputs can turn off before data setup starts. When it does not, only the minimum strobe width and the data setup apply.

Top module: `sram_cycle_seq`

## Requirements
- R1: `mem_we_n` is low only while `mem_ce_n` is low and at least one bit of `mem_lane_n` is low. `mem_lane_n[i]` is low exactly when `req_sel[i]` of the accepted request was 1 and chip enable is active. Lane i covers data bits `[8i+7:8i]`, so bit 1 is the upper byte and bit 0 the lower byte.
- R2: `mem_addr` takes the request address only on the clock edge that accepts a request, which comes after a cycle with chip enable high. The strobe is high in the cycle where the address changes, and the address is held until the next acceptance.
- R3: A write with a nonzero select starts with `T_AS` cycles in which chip enable and the selected lanes are low and the strobe is high.
- R4: The strobe is then low for PW cycles. With `OE_LOW_WR`=1, PW = max(`T_WP`, `T_WZ`+`T_DW`) and `mem_oe_n` is low through setup and strobe. With `OE_LOW_WR`=0, PW = max(`T_WP`, `T_DW`) and `mem_oe_n` is high during the write.
- R5: The data drivers turn on at strobe cycle `T_WZ` (`OE_LOW_WR`=1) or at strobe cycle 0 (`OE_LOW_WR`=0). They stay on for `T_DH` cycles after the strobe rises and present the accepted write data unchanged.
- R6: After the strobe rises, chip enable, strobe, output enable and lane enables are all high for max(`T_DH`, `T_WR`) cycles before the sequencer returns to idle.
- R7: A read with a nonzero select holds chip enable, output enable and the selected lanes low for `T_ACC` cycles. It samples `mem_dq_i` at the end of the last of those cycles, with unselected lanes forced to zero. `T_TA` inactive turnaround cycles follow before idle.
- R8: A request with select 0 drives no strobe, chip enable or lane enable. It completes with `done` in the following cycle. A read with select 0 sets `rd_data` to zero.
- R9: `req_ready` is high only when idle. A request while `req_ready` is low is ignored. `done` is high for exactly the first idle cycle after each accepted request.
- R10: During reset the memory controls are high, the drivers are off, `req_ready`=1, `done`=0, and `rd_data` and `mem_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | LANES*LANE_W | Write data |
| req_sel | input | LANES | Lane select, 1 = lane taking part |
| req_ready | output | 1 | Sequencer idle, request will be accepted |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | LANES*LANE_W | Last read result |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | LANES | Byte lane enables, active low |
| mem_dq_o | output | LANES*LANE_W | Data to the bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | LANES*LANE_W | Data from the bus |

## Verification
Some rules are checked on every cycle. The strobe is never low without chip enable and a lane. The address moves only while the strobe is high and after a chip-enable-high cycle. Strobe width and write recovery meet their minimums. The drivers are never on while output enable is low unless the strobe has been low for the turn-off time. Driven data never changes while driven. The exact phase lengths, the lane-masked read value, the zero-select shortcut, the stall of a request while busy, and write data actually reaching the addressed bytes are shown only by the bench. It runs scenarios against a cycle-by-cycle reference and a behavioural memory.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WSET = 3'd1,
      ST_WPUL = 3'd2,
      ST_WPST = 3'd3,
      ST_RACC = 3'd4,
      ST_RGAP = 3'd5
   } seq_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_seq_phase_ctr.sv
module sram_seq_phase_ctr #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] len,
   output logic [CNT_W-1:0] idx,
   output logic             last
);

   logic [CNT_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clr) begin
         idx_q <= '0;
      end else begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign idx  = idx_q;
   assign last = (idx_q == (len - 1'b1));

endmodule

// File: rtl/sram_seq_lanes.sv
module sram_seq_lanes #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic [LANES-1:0]        sel,
   input  logic                    active,
   input  logic [LANES*LANE_W-1:0] raw,
   output logic [LANES-1:0]        lane_n,
   output logic [LANES*LANE_W-1:0] masked
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_n[i] = ~(sel[i] & active);
      assign masked[i*LANE_W +: LANE_W] = sel[i] ? raw[i*LANE_W +: LANE_W] : '0;
   end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_seq_pkg::*;
#(
   parameter int CNT_W    = 3,
   parameter int LEN_AS   = 1,
   parameter int LEN_PUL  = 1,
   parameter int LEN_POST = 1,
   parameter int LEN_ACC  = 1,
   parameter int LEN_GAP  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             fire_we,
   input  logic             fire_any,
   input  logic             phase_last,
   output seq_state_e       state,
   output logic [CNT_W-1:0] phase_len,
   output logic             phase_clr,
   output logic             done
);

   localparam logic [CNT_W-1:0] L_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] L_AS   = CNT_W'(LEN_AS);
   localparam logic [CNT_W-1:0] L_PUL  = CNT_W'(LEN_PUL);
   localparam logic [CNT_W-1:0] L_POST = CNT_W'(LEN_POST);
   localparam logic [CNT_W-1:0] L_ACC  = CNT_W'(LEN_ACC);
   localparam logic [CNT_W-1:0] L_GAP  = CNT_W'(LEN_GAP);

   seq_state_e state_q;
   seq_state_e state_d;
   logic       done_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (fire && fire_any) begin
               state_d = fire_we ? ST_WSET : ST_RACC;
            end
         end
         ST_WSET: if (phase_last) state_d = ST_WPUL;
         ST_WPUL: if (phase_last) state_d = ST_WPST;
         ST_WPST: if (phase_last) state_d = ST_IDLE;
         ST_RACC: if (phase_last) state_d = ST_RGAP;
         ST_RGAP: if (phase_last) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_q)
         ST_WSET: phase_len = L_AS;
         ST_WPUL: phase_len = L_PUL;
         ST_WPST: phase_len = L_POST;
         ST_RACC: phase_len = L_ACC;
         ST_RGAP: phase_len = L_GAP;
         default: phase_len = L_ONE;
      endcase
   end

   assign phase_clr = (state_d != state_q) || (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= ((state_q != ST_IDLE) && (state_d == ST_IDLE)) ||
                    ((state_q == ST_IDLE) && fire && !fire_any);
      end
   end

   assign state = state_q;
   assign done  = done_q;

endmodule

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int LANE_W    = 8,
   parameter int LANES     = 2,
   parameter int T_AS      = 1,
   parameter int T_WP      = 3,
   parameter int T_WZ      = 2,
   parameter int T_DW      = 2,
   parameter int T_DH      = 1,
   parameter int T_WR      = 2,
   parameter int T_ACC     = 3,
   parameter int T_TA      = 1,
   parameter int OE_LOW_WR = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req,
   input  logic                    req_we,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [LANES*LANE_W-1:0] req_wdata,
   input  logic [LANES-1:0]        req_sel,
   output logic                    req_ready,
   output logic                    done,
   output logic [LANES*LANE_W-1:0] rd_data,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic                    mem_ce_n,
   output logic                    mem_we_n,
   output logic                    mem_oe_n,
   output logic [LANES-1:0]        mem_lane_n,
   output logic [LANES*LANE_W-1:0] mem_dq_o,
   output logic                    mem_dq_oe,
   input  logic [LANES*LANE_W-1:0] mem_dq_i
);

   localparam int DATA_W  = LANES * LANE_W;
   localparam int DRV_OFS = (OE_LOW_WR != 0) ? T_WZ : 0;
   localparam int PULSE   = imax(T_WP, DRV_OFS + T_DW);
   localparam int POST    = imax(T_DH, T_WR);
   localparam int MAXLEN  = imax(imax(imax(T_AS, PULSE), imax(POST, T_ACC)), T_TA);
   localparam int CNT_W   = imax(1, $clog2(MAXLEN + 1));
   localparam logic [CNT_W-1:0] DRV_C = CNT_W'(DRV_OFS);
   localparam logic [CNT_W-1:0] DH_C  = CNT_W'(T_DH);

   // elaboration-time parameter checks
   if (T_AS < 1 || T_WP < 1 || T_DW < 1 || T_DH < 1 || T_WR < 1 ||
       T_ACC < 1 || T_TA < 1 || T_WZ < 0) begin : g_bad_timing
      $error("sram_cycle_seq: every interval must be at least one cycle");
   end
   if (ADDR_W < 1 || LANES < 1 || LANE_W < 1) begin : g_bad_shape
      $error("sram_cycle_seq: address and lane geometry must be positive");
   end
   if (OE_LOW_WR != 0 && OE_LOW_WR != 1) begin : g_bad_mode
      $error("sram_cycle_seq: OE_LOW_WR selects 0 or 1");
   end

   seq_state_e              state;
   logic [CNT_W-1:0]        phase_len;
   logic [CNT_W-1:0]        phase_idx;
   logic                    phase_clr;
   logic                    phase_last;
   logic                    fire;
   logic                    fire_any;
   logic                    ce_act;
   logic                    oe_act;
   logic                    drive_pulse;
   logic                    drive_hold;
   logic [ADDR_W-1:0]       addr_q;
   logic [DATA_W-1:0]       wdata_q;
   logic [LANES-1:0]        sel_q;
   logic [DATA_W-1:0]       rd_q;
   logic [DATA_W-1:0]       rd_masked;

   assign req_ready = (state == ST_IDLE);
   assign fire      = req && req_ready;
   assign fire_any  = |req_sel;

   sram_seq_fsm #(
      .CNT_W    (CNT_W),
      .LEN_AS   (T_AS),
      .LEN_PUL  (PULSE),
      .LEN_POST (POST),
      .LEN_ACC  (T_ACC),
      .LEN_GAP  (T_TA)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .fire_we    (req_we),
      .fire_any   (fire_any),
      .phase_last (phase_last),
      .state      (state),
      .phase_len  (phase_len),
      .phase_clr  (phase_clr),
      .done       (done)
   );

   sram_seq_phase_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase_clr),
      .len   (phase_len),
      .idx   (phase_idx),
      .last  (phase_last)
   );

   assign ce_act = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_RACC);

   sram_seq_lanes #(
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_lanes (
      .sel    (sel_q),
      .active (ce_act),
      .raw    (mem_dq_i),
      .lane_n (mem_lane_n),
      .masked (rd_masked)
   );

   // output-enable policy during writes
   if (OE_LOW_WR != 0) begin : g_oe_low
      assign oe_act = (state == ST_RACC) || (state == ST_WSET) || (state == ST_WPUL);
   end else begin : g_oe_high
      assign oe_act = (state == ST_RACC);
   end

   // driver turn-on point inside the strobe
   if (DRV_OFS == 0) begin : g_drv_now
      assign drive_pulse = (state == ST_WPUL);
   end else begin : g_drv_late
      assign drive_pulse = (state == ST_WPUL) && (phase_idx >= DRV_C);
   end

   assign drive_hold = (state == ST_WPST) && (phase_idx < DH_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         sel_q   <= '0;
      end else if (fire) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         sel_q   <= req_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if ((state == ST_RACC) && phase_last) begin
         rd_q <= rd_masked;
      end else if (fire && !req_we && !fire_any) begin
         rd_q <= '0;
      end
   end

   assign mem_addr  = addr_q;
   assign mem_ce_n  = ~ce_act;
   assign mem_we_n  = ~(state == ST_WPUL);
   assign mem_oe_n  = ~oe_act;
   assign mem_dq_o  = wdata_q;
   assign mem_dq_oe = drive_pulse || drive_hold;
   assign rd_data   = rd_q;

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
   parameter int ADDR_W    = 14,
   parameter int LANES     = 2,
   parameter int DATA_W    = 16,
   parameter int T_WP      = 3,
   parameter int T_WZ      = 2,
   parameter int T_DW      = 2,
   parameter int T_WR      = 2,
   parameter int OE_LOW_WR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [LANES-1:0]  mem_lane_n,
   input logic [DATA_W-1:0] mem_dq_o,
   input logic              mem_dq_oe
);

   localparam int DRV_MIN   = (OE_LOW_WR != 0) ? T_WZ : 0;
   localparam int PULSE_MIN = (T_WP > DRV_MIN + T_DW) ? T_WP : DRV_MIN + T_DW;

   logic [15:0] low_run;
   logic [15:0] since_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= '0;
         since_wr <= '1;
      end else begin
         if (!mem_we_n) begin
            low_run  <= (low_run == '1) ? low_run : low_run + 1'b1;
            since_wr <= '0;
         end else begin
            low_run  <= '0;
            since_wr <= (since_wr == '1) ? since_wr : since_wr + 1'b1;
         end
      end
   end

   p_strobe_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && (mem_lane_n != '1)));

   p_addr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr != $past(mem_addr)) |-> ($past(mem_ce_n) && mem_we_n));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && (mem_lane_n == '1) && !mem_dq_oe));

   p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (32'(low_run) >= PULSE_MIN));

   if (OE_LOW_WR != 0) begin : g_chk_oe_low
      p_oe_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !mem_we_n |-> !mem_oe_n);
   end else begin : g_chk_oe_high
      p_oe_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !mem_we_n |-> mem_oe_n);
   end

   p_drive_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && !mem_oe_n) |-> (!mem_we_n && (32'(low_run) >= T_WZ)));

   p_data_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

   p_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> (32'(since_wr) >= T_WR));

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_ready && mem_ce_n && !mem_dq_oe));

endmodule

bind sram_cycle_seq sram_seq_chk #(
   .ADDR_W    (ADDR_W),
   .LANES     (LANES),
   .DATA_W    (LANES * LANE_W),
   .T_WP      (T_WP),
   .T_WZ      (T_WZ),
   .T_DW      (T_DW),
   .T_WR      (T_WR),
   .OE_LOW_WR (OE_LOW_WR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .done       (done),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_lane_n (mem_lane_n),
   .mem_dq_o   (mem_dq_o),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_cycle_seq_tb.sv
`timescale 1ns/1ps
module sram_cycle_seq_tb;

   localparam int AW  = 10;
   localparam int AS  = 1;
   localparam int WP  = 3;
   localparam int WZ  = 2;
   localparam int DW  = 2;
   localparam int DH  = 1;
   localparam int WR  = 2;
   localparam int ACC = 3;
   localparam int TA  = 1;
   localparam int OEL = 1;
   localparam int DRV  = OEL ? WZ : 0;
   localparam int PW   = (WP > DRV + DW) ? WP : DRV + DW;
   localparam int POST = (DH > WR) ? DH : WR;

   typedef struct packed {
      logic [1:0]    kind;   // 0 plain, 1 post-write, 2 zero-select completion
      logic          ready;
      logic          done;
      logic          ce_n;
      logic          we_n;
      logic          oe_n;
      logic [1:0]    lane_n;
      logic          dq_oe;
      logic [AW-1:0] addr;
      logic [15:0]   dq;
      logic [15:0]   rd;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0]   req_wdata = '0;
   logic [1:0]    req_sel = '0;
   logic          req_ready;
   logic          done;
   logic [15:0]   rd_data;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n;
   logic          mem_we_n;
   logic          mem_oe_n;
   logic [1:0]    mem_lane_n;
   logic [15:0]   mem_dq_o;
   logic          mem_dq_oe;
   logic [15:0]   mem_dq_i;

   logic [15:0] sram [0:(1<<AW)-1];
   logic [15:0] gold [0:(1<<AW)-1];

   exp_t          q[$];
   logic [AW-1:0] last_addr = '0;
   logic [15:0]   last_rd = '0;
   logic          cur_ready = 1'b1;
   int            checks = 0;
   int            errors = 0;

   always #2 clk = ~clk;

   sram_cycle_seq #(
      .ADDR_W (AW), .LANE_W (8), .LANES (2),
      .T_AS (AS), .T_WP (WP), .T_WZ (WZ), .T_DW (DW), .T_DH (DH),
      .T_WR (WR), .T_ACC (ACC), .T_TA (TA), .OE_LOW_WR (OEL)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .req (req), .req_we (req_we),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_sel (req_sel),
      .req_ready (req_ready), .done (done), .rd_data (rd_data),
      .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_we_n (mem_we_n),
      .mem_oe_n (mem_oe_n), .mem_lane_n (mem_lane_n), .mem_dq_o (mem_dq_o),
      .mem_dq_oe (mem_dq_oe), .mem_dq_i (mem_dq_i)
   );

   // behavioural memory on the pins
   always_comb begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n) mem_dq_i = sram[mem_addr];
      else                                    mem_dq_i = 16'hDEAD;
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) sram[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      forever begin
         @(negedge clk);
         if (!mem_we_n && !mem_ce_n && mem_dq_oe) begin
            if (!mem_lane_n[1]) sram[mem_addr][15:8] = mem_dq_o[15:8];
            if (!mem_lane_n[0]) sram[mem_addr][7:0]  = mem_dq_o[7:0];
         end
      end
   end

   task automatic check(input logic ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic exp_t idle_rec(input logic [AW-1:0] a, input logic [15:0] r);
      exp_t e;
      e = '0;
      e.ready = 1'b1; e.ce_n = 1'b1; e.we_n = 1'b1; e.oe_n = 1'b1;
      e.lane_n = 2'b11; e.addr = a; e.rd = r;
      return e;
   endfunction

   task automatic push_seq(input logic we, input logic [AW-1:0] a,
                           input logic [15:0] d, input logic [1:0] m);
      exp_t e;
      logic [15:0] val;
      if (m == 2'b00) begin
         val = we ? last_rd : 16'h0000;
         e = idle_rec(a, val); e.done = 1'b1; e.kind = 2'd2;
         q.push_back(e);
         last_addr = a; last_rd = val;
         return;
      end
      if (we) begin
         for (int k = 0; k < AS; k++) begin
            e = idle_rec(a, last_rd); e.ready = 0; e.ce_n = 0;
            e.oe_n = ~1'(OEL); e.lane_n = ~m;
            q.push_back(e);
         end
         for (int j = 0; j < PW; j++) begin
            e = idle_rec(a, last_rd); e.ready = 0; e.ce_n = 0; e.we_n = 0;
            e.oe_n = ~1'(OEL); e.lane_n = ~m; e.dq_oe = (j >= DRV); e.dq = d;
            q.push_back(e);
         end
         for (int j = 0; j < POST; j++) begin
            e = idle_rec(a, last_rd); e.ready = 0; e.kind = 2'd1;
            e.dq_oe = (j < DH); e.dq = d;
            q.push_back(e);
         end
         if (m[1]) gold[a][15:8] = d[15:8];
         if (m[0]) gold[a][7:0]  = d[7:0];
         e = idle_rec(a, last_rd); e.done = 1'b1; e.kind = 2'd1;
         q.push_back(e);
         last_addr = a;
      end else begin
         val = {m[1] ? gold[a][15:8] : 8'h00, m[0] ? gold[a][7:0] : 8'h00};
         for (int k = 0; k < ACC; k++) begin
            e = idle_rec(a, last_rd); e.ready = 0; e.ce_n = 0; e.oe_n = 0; e.lane_n = ~m;
            q.push_back(e);
         end
         for (int j = 0; j < TA; j++) begin
            e = idle_rec(a, val); e.ready = 0;
            q.push_back(e);
         end
         e = idle_rec(a, val); e.done = 1'b1;
         q.push_back(e);
         last_addr = a; last_rd = val;
      end
   endtask

   task automatic tick();
      exp_t e;
      string t6;
      @(negedge clk);
      if (q.size() > 0) e = q.pop_front();
      else              e = idle_rec(last_addr, last_rd);
      cur_ready = e.ready;
      t6 = (e.kind == 2'd1) ? "R6" : (e.kind == 2'd2) ? "R8" : "";
      check(mem_ce_n == e.ce_n, (t6 != "") ? t6 : "R3", "ce_n", 32'(mem_ce_n), 32'(e.ce_n));
      check(mem_we_n == e.we_n, (t6 != "") ? t6 : "R4", "we_n", 32'(mem_we_n), 32'(e.we_n));
      check(mem_oe_n == e.oe_n, (t6 != "") ? t6 : "R4", "oe_n", 32'(mem_oe_n), 32'(e.oe_n));
      check(mem_lane_n == e.lane_n, (t6 != "") ? t6 : "R1", "lane_n", 32'(mem_lane_n), 32'(e.lane_n));
      check(mem_addr == e.addr, "R2", "addr", 32'(mem_addr), 32'(e.addr));
      check(mem_dq_oe == e.dq_oe, "R5", "dq_oe", 32'(mem_dq_oe), 32'(e.dq_oe));
      if (e.dq_oe) check(mem_dq_o == e.dq, "R5", "dq_o", 32'(mem_dq_o), 32'(e.dq));
      check(req_ready == e.ready, "R9", "ready", 32'(req_ready), 32'(e.ready));
      check(done == e.done, (t6 == "R8") ? "R8" : "R9", "done", 32'(done), 32'(e.done));
      check(rd_data == e.rd, (t6 == "R8") ? "R8" : "R7", "rd_data", 32'(rd_data), 32'(e.rd));
   endtask

   task automatic issue(input logic we, input logic [AW-1:0] a,
                        input logic [15:0] d, input logic [1:0] m);
      req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_sel = m;
      while (!cur_ready) tick();
      push_seq(we, a, d, m);
      tick();
      req = 1'b0;
   endtask

   // R9: a request raised for one busy cycle must leave no trace
   task automatic junk_while_busy(input logic [AW-1:0] a);
      if (!cur_ready) begin
         req = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = 16'hFFFF; req_sel = 2'b11;
         tick();
         req = 1'b0;
      end
   endtask

   task automatic drain();
      while (q.size() > 0) tick();
      tick();
   endtask

   initial begin
      logic [15:0] lf;
      for (int i = 0; i < (1 << AW); i++) gold[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      repeat (3) @(negedge clk);
      // R10: reset values
      check(mem_ce_n && mem_we_n && mem_oe_n && (mem_lane_n == 2'b11), "R10", "controls",
            32'({mem_ce_n, mem_we_n, mem_oe_n, mem_lane_n}), 32'h1F);
      check(!mem_dq_oe, "R10", "dq_oe", 32'(mem_dq_oe), 0);
      check(req_ready && !done, "R10", "ready/done", 32'({req_ready, done}), 32'h2);
      check((rd_data == 0) && (mem_addr == 0), "R10", "rd/addr",
            32'({rd_data, 6'(0), mem_addr}), 0);
      rst_n = 1'b1;
      tick();

      issue(1'b1, 10'd5, 16'hA1B2, 2'b11);   // R3 R4 R5 R6 full write
      drain();
      issue(1'b0, 10'd5, 16'h0000, 2'b11);   // R7 read back
      drain();
      issue(1'b1, 10'd5, 16'h77EE, 2'b10);   // R1 upper lane only
      drain();
      issue(1'b0, 10'd5, 16'h0000, 2'b11);
      drain();
      issue(1'b1, 10'd9, 16'h3344, 2'b01);   // R1 lower lane only
      drain();
      issue(1'b0, 10'd9, 16'h0000, 2'b01);   // R7 unselected upper lane reads zero
      drain();
      issue(1'b0, 10'd9, 16'h0000, 2'b10);   // R7 unselected lower lane reads zero
      drain();
      issue(1'b1, 10'd5, 16'hFFFF, 2'b00);   // R8 zero-select write
      drain();
      issue(1'b0, 10'd5, 16'h0000, 2'b11);   // R8 memory unchanged
      drain();
      issue(1'b0, 10'd7, 16'h0000, 2'b00);   // R8 zero-select read clears rd_data
      drain();
      // R9 back-to-back stall: write followed at once by read
      issue(1'b1, 10'd12, 16'hC0DE, 2'b11);
      issue(1'b0, 10'd12, 16'h0000, 2'b11);
      issue(1'b0, 10'd5, 16'h0000, 2'b00);
      issue(1'b1, 10'd13, 16'h1234, 2'b11);
      junk_while_busy(10'd13);               // R9 ignored while busy
      drain();
      issue(1'b0, 10'd13, 16'h0000, 2'b11);
      drain();
      lf = 16'hACE1;
      for (int n = 0; n < 40; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         issue(lf[2], {6'd0, lf[7:4]}, lf ^ 16'h9C3A, lf[1:0]);
         if (lf[9]) drain();
      end
      drain();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule